// File: doc/BRIEF.md
# Line-Interface Serial Register Port

This block is a bus master for the small configuration registers of a line interface unit. Those registers are reached over a bit-serial link made of a select per device, a serial clock, a data line out and a data line in. A host asks for one transaction with a single-cycle start strobe. The strobe carries a read/write flag, a 4-bit register address, a slot index that picks one of several attached devices, and a 5-bit value for writes. The block then runs a fixed 16-bit frame on the serial pins. When the frame is over it raises a one-cycle done pulse. For reads, that pulse comes with the captured byte.

The frame has three parts:
- a direction bit;
- a 7-bit address field: the 4 address bits, least significant first, then zero padding;
- an 8-bit data field: on writes, the 5 value bits least significant first and then zero padding; on reads, the 8 bits shifted in from the device, least significant first.

The serial clock half-period is set by a parameter in system clock cycles. Outgoing data changes only while the serial clock is low. Incoming data is sampled during the high phase.

Top module: `liu_sport_master`

## Requirements
- R1: Frame bit 0, the first bit clocked out, is the direction flag: 1 for a read and 0 for a write.
- R2: Frame bits 1 to 4 carry the register address, least significant bit first, and frame bits 5 to 7 are zero.
- R3: Every frame has exactly 16 serial clock high pulses. On a write, frame bits 8 to 12 carry the value least significant bit first, and bits 13 to 15 are zero.
- R4: On a read, data-in is sampled in the high phase of pulses 9 to 16, least significant bit first. The full 8-bit byte, including bits 7 to 5, appears on the read value output during the done pulse and holds until the next read completes.
- R5: Data-out changes only while the serial clock is low, and it is zero during the data field of a read.
- R6: Every serial clock high phase lasts HALF_CYC system cycles. With start accepted at clock edge 0, done is high in cycle 34*HALF_CYC+1.
- R7: Only the select bit of the requested slot is asserted during a transaction. It rises at least one half-period before the first serial clock pulse and stays steady until after the clock has returned low.
- R8: Done is a one-cycle pulse. In the cycle before it, select, serial clock and data-out are all zero. Busy is high from the cycle after start until done, and low during done.
- R9: A start strobe that arrives while busy is ignored: the frame in progress, its read value and its length are unchanged.
- R10: After reset, busy, done, every select, the serial clock, data-out and the read value are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Single-cycle transaction request, taken only when idle |
| rd_i | input | 1 | 1 = read, 0 = write |
| reg_addr_i | input | 4 | Register address |
| slot_i | input | SLOT_W (2) | Index of the target device |
| wr_val_i | input | 5 | Value to write |
| busy_o | output | 1 | Transaction in progress |
| done_o | output | 1 | One-cycle completion pulse |
| rd_val_o | output | 8 | Byte captured by the last read |
| sel_o | output | NUM_SLOTS (4) | Per-slot device select, active high |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data to the device |
| sdi_i | input | 1 | Serial data from the device |

## Verification
Two behaviours are hard to reach from the ports. The first is a start strobe that lands in the middle of a frame: the bench raises start with different, randomised fields a few cycles into a running transaction. It then checks that the captured frame, the read value and the latency all still belong to the original request. The second is the pass-through of the upper three read bits, which a device only shows if it drives them. The bench's device model is seeded with random full bytes, so bits 7 to 5 vary. Directed cases cover the extreme addresses and values and every slot. Writes are followed by read-backs, and a random mix fills in the rest.

// File: rtl/liu_sport_pkg.sv
package liu_sport_pkg;

    localparam int ADDR_BITS  = 4;
    localparam int ADDR_FIELD = 7;
    localparam int VAL_BITS   = 5;
    localparam int VAL_FIELD  = 8;
    localparam int RX_BITS    = VAL_FIELD;

    localparam int FRAME_BITS = 1 + ADDR_FIELD + VAL_FIELD;
    localparam int RX_FIRST   = 1 + ADDR_FIELD;
    localparam int BITCNT_W   = $clog2(FRAME_BITS);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_TRAIL,
        ST_CLEAR,
        ST_DONE
    } sport_state_e;

    typedef struct packed {
        logic                 rd;
        logic [ADDR_BITS-1:0] addr;
        logic [VAL_BITS-1:0]  wval;
    } sport_req_t;

    // Serial frame laid out with bit 0 as the first bit on the wire.
    function automatic logic [FRAME_BITS-1:0] build_frame(input sport_req_t r);
        logic [FRAME_BITS-1:0] f;
        f = '0;
        f[0] = r.rd;
        f[1 +: ADDR_BITS] = r.addr;
        if (!r.rd) begin
            f[RX_FIRST +: VAL_BITS] = r.wval;
        end
        return f;
    endfunction

    function automatic logic in_frame(input sport_state_e s);
        return (s == ST_LEAD) || (s == ST_LOW) || (s == ST_HIGH) || (s == ST_TRAIL);
    endfunction

endpackage

// File: rtl/sport_phase_timer.sv
module sport_phase_timer #(
    parameter int HALF_CYC = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic clear,
    input  logic run,
    output logic tick
);
    localparam int CW = (HALF_CYC > 1) ? $clog2(HALF_CYC) : 1;

    logic [CW-1:0] cnt;

    assign tick = run && (cnt == CW'(HALF_CYC - 1));

    always_ff @(posedge clk) begin
        if (rst || clear || !run) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/sport_shifter.sv
module sport_shifter
    import liu_sport_pkg::*;
(
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  load,
    input  logic [FRAME_BITS-1:0] frame,
    input  logic                  advance,
    input  logic                  capture,
    input  logic                  sdi,
    output logic                  sdo_bit,
    output logic [RX_BITS-1:0]    rx_byte
);
    logic [FRAME_BITS-1:0] tx_q;
    logic [RX_BITS-1:0]    rx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx_q <= '0;
        end else if (load) begin
            tx_q <= frame;
        end else if (advance) begin
            tx_q <= {1'b0, tx_q[FRAME_BITS-1:1]};
        end
    end

    // First received bit ends up in bit 0 after RX_BITS shifts.
    always_ff @(posedge clk) begin
        if (rst || load) begin
            rx_q <= '0;
        end else if (capture) begin
            rx_q <= {sdi, rx_q[RX_BITS-1:1]};
        end
    end

    assign sdo_bit = tx_q[0];
    assign rx_byte = rx_q;
endmodule

// File: rtl/sport_slot_select.sv
module sport_slot_select #(
    parameter int NUM_SLOTS = 4,
    parameter int SLOT_W    = 2
) (
    input  logic [SLOT_W-1:0]    slot,
    input  logic                 en,
    output logic [NUM_SLOTS-1:0] sel
);
    for (genvar g = 0; g < NUM_SLOTS; g++) begin : g_sel
        assign sel[g] = en && (slot == SLOT_W'(g));
    end
endmodule

// File: rtl/liu_sport_master.sv
module liu_sport_master
    import liu_sport_pkg::*;
#(
    parameter  int NUM_SLOTS = 4,
    parameter  int HALF_CYC  = 3,
    localparam int SLOT_W    = (NUM_SLOTS > 1) ? $clog2(NUM_SLOTS) : 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 start_i,
    input  logic                 rd_i,
    input  logic [ADDR_BITS-1:0] reg_addr_i,
    input  logic [SLOT_W-1:0]    slot_i,
    input  logic [VAL_BITS-1:0]  wr_val_i,
    output logic                 busy_o,
    output logic                 done_o,
    output logic [RX_BITS-1:0]   rd_val_o,
    output logic [NUM_SLOTS-1:0] sel_o,
    output logic                 sclk_o,
    output logic                 sdo_o,
    input  logic                 sdi_i
);
    sport_state_e          state_q, state_d;
    sport_req_t            req_q, req_in;
    logic [SLOT_W-1:0]     slot_q;
    logic [BITCNT_W-1:0]   bit_q;
    logic [RX_BITS-1:0]    rd_val_q;
    logic                  accept, tick, hi_end, last_bit, capture, frame_on;
    logic                  sdo_bit;
    logic [RX_BITS-1:0]    rx_byte;

    assign req_in   = '{rd: rd_i, addr: reg_addr_i, wval: wr_val_i};
    assign accept   = (state_q == ST_IDLE) && start_i;
    assign frame_on = in_frame(state_q);
    assign hi_end   = (state_q == ST_HIGH) && tick;
    assign last_bit = (bit_q == BITCNT_W'(FRAME_BITS - 1));
    assign capture  = hi_end && req_q.rd && (bit_q >= BITCNT_W'(RX_FIRST));

    sport_phase_timer #(.HALF_CYC(HALF_CYC)) u_timer (
        .clk   (clk),
        .rst   (rst),
        .clear (accept),
        .run   (frame_on),
        .tick  (tick)
    );

    sport_shifter u_shift (
        .clk     (clk),
        .rst     (rst),
        .load    (accept),
        .frame   (build_frame(req_in)),
        .advance (hi_end),
        .capture (capture),
        .sdi     (sdi_i),
        .sdo_bit (sdo_bit),
        .rx_byte (rx_byte)
    );

    sport_slot_select #(.NUM_SLOTS(NUM_SLOTS), .SLOT_W(SLOT_W)) u_sel (
        .slot (slot_q),
        .en   (frame_on),
        .sel  (sel_o)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LEAD;
            ST_LEAD:  if (tick)    state_d = ST_LOW;
            ST_LOW:   if (tick)    state_d = ST_HIGH;
            ST_HIGH:  if (tick)    state_d = last_bit ? ST_TRAIL : ST_LOW;
            ST_TRAIL: if (tick)    state_d = ST_CLEAR;
            ST_CLEAR:              state_d = ST_DONE;
            ST_DONE:               state_d = ST_IDLE;
            default:               state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= ST_IDLE;
            req_q    <= '0;
            slot_q   <= '0;
            bit_q    <= '0;
            rd_val_q <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                req_q  <= req_in;
                slot_q <= slot_i;
                bit_q  <= '0;
            end else if (hi_end && !last_bit) begin
                bit_q <= bit_q + 1'b1;
            end
            if ((state_q == ST_CLEAR) && req_q.rd) begin
                rd_val_q <= rx_byte;
            end
        end
    end

    assign busy_o   = (state_q != ST_IDLE) && (state_q != ST_DONE);
    assign done_o   = (state_q == ST_DONE);
    assign rd_val_o = rd_val_q;
    assign sclk_o   = (state_q == ST_HIGH);
    assign sdo_o    = ((state_q == ST_LOW) || (state_q == ST_HIGH)) && sdo_bit;
endmodule

// File: rtl/liu_sport_checker.sv
module liu_sport_checker #(
    parameter int NUM_SLOTS = 4,
    parameter int HALF_CYC  = 3
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 busy_o,
    input logic                 done_o,
    input logic [NUM_SLOTS-1:0] sel_o,
    input logic                 sclk_o,
    input logic                 sdo_o
);
    logic [15:0] hi_run;

    always_ff @(posedge clk) begin
        if (rst || !sclk_o) begin
            hi_run <= '0;
        end else begin
            hi_run <= hi_run + 1'b1;
        end
    end

    // R7: at most one device selected
    p_one_sel_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel_o));

    // R7: the clock only pulses with a device selected
    p_clk_needs_sel_r7: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> (sel_o != '0));

    // R7: the select does not move within a transaction
    p_sel_steady_r7: assert property (@(posedge clk) disable iff (rst)
        ((sel_o != '0) && ($past(sel_o) != '0)) |-> $stable(sel_o));

    // R5: data-out is stable across the rise and the whole high phase
    p_sdo_stable_r5: assert property (@(posedge clk) disable iff (rst)
        sclk_o |-> $stable(sdo_o));

    // R6: every high phase lasts HALF_CYC cycles
    p_high_len_r6: assert property (@(posedge clk) disable iff (rst)
        $fell(sclk_o) |-> (hi_run == 16'(HALF_CYC)));

    // R8: serial pins were quiet in the cycle before done
    p_done_quiet_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> $past((sel_o == '0) && !sclk_o && !sdo_o));

    // R8: done is a single-cycle pulse, with busy low
    p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);
    p_done_not_busy_r8: assert property (@(posedge clk) disable iff (rst)
        done_o |-> !busy_o);

    // R10: no serial activity while idle
    p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> (!sclk_o && (sel_o == '0)));
endmodule

bind liu_sport_master liu_sport_checker #(
    .NUM_SLOTS (NUM_SLOTS),
    .HALF_CYC  (HALF_CYC)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .busy_o (busy_o),
    .done_o (done_o),
    .sel_o  (sel_o),
    .sclk_o (sclk_o),
    .sdo_o  (sdo_o)
);

// File: tb/sim_liu_sport_master.sv
module sim_liu_sport_master;
    localparam int NS   = 4;
    localparam int HALF = 3;
    localparam int LAT  = 34 * HALF + 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       start_i = 1'b0, rd_i = 1'b0, sdi_i = 1'b0;
    logic [3:0] reg_addr_i = '0;
    logic [1:0] slot_i = '0;
    logic [4:0] wr_val_i = '0;
    logic       busy_o, done_o, sclk_o, sdo_o;
    logic [7:0] rd_val_o;
    logic [3:0] sel_o;

    liu_sport_master #(.NUM_SLOTS(NS), .HALF_CYC(HALF)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .rd_i(rd_i),
        .reg_addr_i(reg_addr_i), .slot_i(slot_i), .wr_val_i(wr_val_i),
        .busy_o(busy_o), .done_o(done_o), .rd_val_o(rd_val_o),
        .sel_o(sel_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i)
    );

    always #10 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int cyc = 0;
    bit ended = 0;

    logic [7:0]  mem [NS][16];
    logic [15:0] mon_bits;
    int          mon_cnt;
    bit          sel_bad;
    logic [3:0]  exp_sel;
    logic [7:0]  slave_byte;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc == 150000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=0", cyc);
            finish_run();
        end
    end

    // Device model: records outgoing bits on each rise, drives read data while the clock is low.
    always @(posedge sclk_o) begin
        if (mon_cnt < 16) mon_bits[mon_cnt] = sdo_o;
        if (sel_o !== exp_sel) sel_bad = 1;
        mon_cnt++;
    end

    always @(negedge sclk_o) begin
        if (mon_bits[0] && mon_cnt >= 8 && mon_cnt < 16) begin
            if (mon_cnt == 8) begin
                slave_byte = 8'h00;
                for (int s = 0; s < NS; s++)
                    if (sel_o[s]) slave_byte = mem[s][mon_bits[4:1]];
            end
            sdi_i = slave_byte[mon_cnt - 8];
        end
    end

    function automatic logic [15:0] exp_frame(input logic rd, input logic [3:0] a, input logic [4:0] v);
        logic [15:0] f;
        f = 16'h0;
        f[0] = rd;
        for (int i = 0; i < 4; i++) f[1 + i] = a[i];
        for (int i = 0; i < 5; i++) f[8 + i] = rd ? 1'b0 : v[i];
        return f;
    endfunction

    task automatic txn(input logic rd, input logic [3:0] a, input logic [1:0] s,
                       input logic [4:0] v, input bit poke);
        logic [15:0] ef;
        logic [7:0]  eb;
        int          lat;
        ef = exp_frame(rd, a, v);
        eb = mem[s][a];
        mon_cnt = 0; mon_bits = '0; sel_bad = 0; sdi_i = 0;
        exp_sel = 4'b0001 << s;
        @(negedge clk);
        rd_i = rd; reg_addr_i = a; slot_i = s; wr_val_i = v; start_i = 1;
        @(negedge clk);
        start_i = 0;
        lat = 0;
        chk(busy_o === 1'b1, "R8 busy after start", busy_o, 1);
        while (!done_o && lat < 2000) begin
            if (poke && lat == 5) begin
                rd_i = ~rd; reg_addr_i = 4'($urandom); slot_i = s + 2'd1;
                wr_val_i = 5'($urandom); start_i = 1;
            end else begin
                start_i = 0;
            end
            @(negedge clk);
            lat++;
        end
        start_i = 0;
        chk(lat == LAT, poke ? "R9 R6 latency" : "R6 latency", lat, LAT);
        chk(mon_bits[0] === rd, poke ? "R9 R1 direction" : "R1 direction", mon_bits[0], rd);
        chk(mon_bits[7:1] === ef[7:1], "R2 address field", mon_bits[7:1], ef[7:1]);
        chk(mon_cnt == 16, "R3 pulse count", mon_cnt, 16);
        if (!rd) chk(mon_bits[15:8] === ef[15:8], "R3 write data field", mon_bits[15:8], ef[15:8]);
        else     chk(mon_bits[15:8] === 8'h00, "R5 sdo zero in read data", mon_bits[15:8], 0);
        chk(!sel_bad, "R7 slot select", sel_bad, 0);
        chk(sel_o === 4'b0 && sclk_o === 1'b0 && sdo_o === 1'b0, "R8 quiet at done",
            {sel_o, sclk_o, sdo_o}, 0);
        if (rd) chk(rd_val_o === eb, poke ? "R9 R4 read value" : "R4 read value", rd_val_o, eb);
        @(negedge clk);
        chk(done_o === 1'b0 && busy_o === 1'b0, "R8 done pulse width", {done_o, busy_o}, 0);
        if (rd) chk(rd_val_o === eb, "R4 read value holds", rd_val_o, eb);
        if (!rd) mem[s][a] = mon_bits[15:8];
    endtask

    initial begin
        void'($urandom(32'h5EED));
        for (int s = 0; s < NS; s++)
            for (int a = 0; a < 16; a++) mem[s][a] = 8'($urandom);
        mem[1][4'hA] = 8'hE5;
        mon_cnt = 16; mon_bits = '0; exp_sel = '0; sel_bad = 0;
        repeat (3) @(negedge clk);
        chk({busy_o, done_o, sel_o, sclk_o, sdo_o, rd_val_o} === '0, "R10 in reset",
            {busy_o, done_o, sel_o, sclk_o, sdo_o, rd_val_o}, 0);
        rst = 0;
        @(negedge clk);
        chk({busy_o, done_o, sel_o, sclk_o, sdo_o, rd_val_o} === '0, "R10 after reset",
            {busy_o, done_o, sel_o, sclk_o, sdo_o, rd_val_o}, 0);

        txn(1'b1, 4'h0, 2'd0, 5'h00, 0);
        txn(1'b1, 4'hA, 2'd1, 5'h00, 0);   // R4 upper bits pass through
        txn(1'b0, 4'hF, 2'd3, 5'h1F, 0);
        txn(1'b1, 4'hF, 2'd3, 5'h00, 0);   // read back, padding bits zero
        txn(1'b0, 4'h1, 2'd2, 5'h15, 1);   // R9 start while busy
        txn(1'b1, 4'h5, 2'd2, 5'h0A, 1);
        txn(1'b1, 4'h1, 2'd2, 5'h00, 0);
        for (int k = 0; k < 40; k++)
            txn(1'($urandom), 4'($urandom), 2'($urandom), 5'($urandom), (k % 7) == 3);
        finish_run();
    end
endmodule